// File: doc/BRIEF.md
# Wide Lane Vector Accumulator

This block holds one 192-bit signed accumulator and updates it lane by lane from two 64-bit vector operands. The first operand comes straight from a vector register. The second operand has already been chosen by the caller. The format input sets how the storage is split:
- Byte format gives eight lanes of 24 bits, each fed by 8-bit vector elements.
- Halfword format gives four lanes of 48 bits, each fed by 16-bit vector elements.

One operation code picks the action:
- a multiply-accumulate variant or an add/subtract variant;
- a partial write of the lanes;
- a read that returns one third of every lane packed into a 64-bit vector.

A pipeline issues one operation per cycle with a valid strobe. Reads are combinational from the current contents and leave them untouched. Writes take effect on the clock edge where the strobe is high. Lane arithmetic wraps at the lane width and never saturates. Scaling, rounding and clamping on the way out are left to a later stage.

Top module: `wide_lane_acc`

## Requirements
- R1: Active-low reset clears all 192 accumulator bits to zero, and `acc_out` shows the accumulator at all times.
- R2: Lane layout:
  - With `fmt`=0, lane i is `acc[24i+23:24i]` and its elements are `vs[8i+7:8i]` and `vt[8i+7:8i]`.
  - With `fmt`=1, lane i is `acc[48i+47:48i]` and its elements are `vs[16i+15:16i]` and `vt[16i+15:16i]`.
  - Elements are signed two's complement.
- R3: The multiply codes use the product of the two elements, p = vs*vt:
  - 0 gives acc+p;
  - 1 gives p;
  - 2 gives acc-p;
  - 3 gives -p.
- R4: The add/subtract codes:
  - 4 gives acc+vs+vt;
  - 5 gives vs+vt;
  - 6 gives acc+vs-vt;
  - 7 gives vs-vt.
- R5: Lane results wrap modulo 2^(lane width), with no saturation. For example, 1024 byte-format multiply-accumulates of -128*-128 starting from zero return each lane to zero.
- R6: Codes 10, 11 and 12 put lane bits [w-1:0], [2w-1:w] and [3w-1:2w] of each lane i on `rd_data[w*i+w-1:w*i]`, where w is 8 (fmt 0) or 16 (fmt 1).
  - The result is combinational.
  - These codes leave the accumulator unchanged.
  - For every other code `rd_data` is zero.
- R7: Code 8 (write high) replaces the top third of each lane with the `vs` element and keeps the lower two thirds.
- R8: Code 9 (write low) sets each lane to {`vs` element, `vt` element sign-extended to 2w bits}.
- R9: Codes 13, 14 and 15 leave the accumulator unchanged.
- R10: The accumulator changes only on a rising clock edge where `valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid | input | 1 | Apply `op` at this clock edge |
| op | input | 4 | Operation code |
| fmt | input | 1 | 0 = eight byte lanes, 1 = four halfword lanes |
| vs | input | 64 | First vector operand |
| vt | input | 64 | Second vector operand, already selected |
| rd_data | output | 64 | Packed slice read result |
| acc_out | output | 192 | Full accumulator contents |

## Verification
Every accumulator bit is visible on `acc_out`. A wrong lane value, a wrong lane boundary or a lost carry therefore appears at the port one cycle after the faulty update. It stays visible until the lane is overwritten. Read-slice errors appear in the same cycle, before the edge, on `rd_data`. Random operation mixes in both formats are compared after every step against a lane-wise model, so a fault in one format or one code shows up within a handful of operations.

// File: rtl/wide_lane_acc.sv
module wide_lane_acc #(
  parameter int EL_W = 8,
  parameter int N_EL = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid,
  input  logic [3:0]              op,
  input  logic                    fmt,
  input  logic [EL_W*N_EL-1:0]    vs,
  input  logic [EL_W*N_EL-1:0]    vt,
  output logic [EL_W*N_EL-1:0]    rd_data,
  output logic [3*EL_W*N_EL-1:0]  acc_out
);
  localparam int VEC_W = EL_W * N_EL;
  localparam int ACC_W = 3 * VEC_W;

  localparam logic [3:0] OP_MULA  = 4'd0;
  localparam logic [3:0] OP_MULL  = 4'd1;
  localparam logic [3:0] OP_MULS  = 4'd2;
  localparam logic [3:0] OP_MULSL = 4'd3;
  localparam logic [3:0] OP_ADDA  = 4'd4;
  localparam logic [3:0] OP_ADDL  = 4'd5;
  localparam logic [3:0] OP_SUBA  = 4'd6;
  localparam logic [3:0] OP_SUBL  = 4'd7;
  localparam logic [3:0] OP_WRH   = 4'd8;
  localparam logic [3:0] OP_WRL   = 4'd9;
  localparam logic [3:0] OP_RDL   = 4'd10;
  localparam logic [3:0] OP_RDM   = 4'd11;
  localparam logic [3:0] OP_RDH   = 4'd12;

  logic [ACC_W-1:0]          acc;
  logic [1:0][ACC_W-1:0]     nxt;
  logic [1:0][VEC_W-1:0]     rdv;
  logic                      is_read;

  assign is_read = (op == OP_RDL) || (op == OP_RDM) || (op == OP_RDH);

  for (genvar f = 0; f < 2; f++) begin : g_fmt
    localparam int EW = EL_W << f;
    localparam int NL = N_EL >> f;
    localparam int LW = 3 * EW;
    for (genvar i = 0; i < NL; i++) begin : g_lane
      logic signed [LW-1:0] a, b, cur, prod, res;
      assign a    = {{(LW-EW){vs[i*EW+EW-1]}}, vs[i*EW +: EW]};
      assign b    = {{(LW-EW){vt[i*EW+EW-1]}}, vt[i*EW +: EW]};
      assign cur  = acc[i*LW +: LW];
      assign prod = a * b;

      always_comb begin
        case (op)
          OP_MULA:  res = cur + prod;
          OP_MULL:  res = prod;
          OP_MULS:  res = cur - prod;
          OP_MULSL: res = -prod;
          OP_ADDA:  res = cur + a + b;
          OP_ADDL:  res = a + b;
          OP_SUBA:  res = cur + a - b;
          OP_SUBL:  res = a - b;
          OP_WRH:   res = {a[EW-1:0], cur[2*EW-1:0]};
          OP_WRL:   res = {a[EW-1:0], b[2*EW-1:0]};
          default:  res = cur;
        endcase
      end

      assign nxt[f][i*LW +: LW] = res;
      assign rdv[f][i*EW +: EW] = (op == OP_RDH) ? cur[2*EW +: EW] :
                                  (op == OP_RDM) ? cur[EW +: EW] : cur[EW-1:0];

      p_wrh_keep_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_WRH && fmt == 1'(f))
        |=> acc[i*LW +: 2*EW] == $past(acc[i*LW +: 2*EW]));

      p_wrh_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_WRH && fmt == 1'(f))
        |=> acc[i*LW+2*EW +: EW] == $past(vs[i*EW +: EW]));

      p_wrl_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_WRL && fmt == 1'(f))
        |=> acc[i*LW +: LW] == $past({vs[i*EW +: EW], {EW{vt[i*EW+EW-1]}}, vt[i*EW +: EW]}));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (valid) acc <= nxt[fmt];
  end

  assign rd_data = is_read ? rdv[fmt] : '0;
  assign acc_out = acc;

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(acc_out));

  p_read_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_read) |=> $stable(acc_out));

  p_spare_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op >= 4'd13) |=> $stable(acc_out));

  p_rd_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op < OP_RDL || op > OP_RDH) |-> rd_data == '0);
endmodule

// File: tb/wide_lane_acc_test.sv
module wide_lane_acc_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [3:0]   op = 4'd0;
  logic         fmt = 1'b0;
  logic [63:0]  vs = '0, vt = '0;
  logic [63:0]  rd_data;
  logic [191:0] acc_out;
  logic [191:0] model = '0;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  wide_lane_acc uut (.clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .fmt(fmt),
                     .vs(vs), .vt(vt), .rd_data(rd_data), .acc_out(acc_out));

  function automatic longint sx(longint v, int w);
    if (v[w-1]) return v - (64'sd1 <<< w);
    return v;
  endfunction

  function automatic longint lane_raw(logic [191:0] acc, int i, int lw);
    logic [191:0] t = acc >> (i*lw);
    return longint'(t[63:0]) & ((64'sd1 <<< lw) - 1);
  endfunction

  function automatic logic [191:0] model_next(logic [191:0] acc, int o, int f,
                                              logic [63:0] s, logic [63:0] t);
    int ew = 8 << f, nl = 8 >> f, lw = 3 * ew;
    longint lm = (64'sd1 <<< lw) - 1, em = (64'sd1 <<< ew) - 1, m2 = (64'sd1 <<< (2*ew)) - 1;
    logic [191:0] r = acc;
    for (int i = 0; i < nl; i++) begin
      longint su = longint'(s >> (i*ew)) & em;
      longint a = sx(su, ew);
      longint b = sx(longint'(t >> (i*ew)) & em, ew);
      longint c = sx(lane_raw(acc, i, lw), lw);
      longint v;
      logic [191:0] msk;
      case (o)
        0: v = c + a*b;
        1: v = a*b;
        2: v = c - a*b;
        3: v = -(a*b);
        4: v = c + a + b;
        5: v = a + b;
        6: v = c + a - b;
        7: v = a - b;
        8: v = (su <<< (2*ew)) | (c & m2);
        9: v = (su <<< (2*ew)) | (b & m2);
        default: v = c;
      endcase
      msk = 192'(lm) << (i*lw);
      r = (r & ~msk) | (192'(v & lm) << (i*lw));
    end
    return r;
  endfunction

  function automatic logic [63:0] model_read(logic [191:0] acc, int o, int f);
    int ew = 8 << f, nl = 8 >> f, lw = 3 * ew;
    logic [63:0] r = '0;
    if (o < 10 || o > 12) return r;
    for (int i = 0; i < nl; i++) begin
      longint sl = (lane_raw(acc, i, lw) >>> ((o - 10) * ew)) & ((64'sd1 <<< ew) - 1);
      r = r | (64'(sl) << (i*ew));
    end
    return r;
  endfunction

  task automatic chk(string req, logic [191:0] act, logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(int o);
    if (o <= 3) return "R3";
    if (o <= 7) return "R4";
    if (o == 8) return "R7";
    if (o == 9) return "R8";
    if (o <= 12) return "R6";
    return "R9";
  endfunction

  task automatic step(int o, int f, logic [63:0] s, logic [63:0] t, logic v);
    op = 4'(o); fmt = f[0]; vs = s; vt = t; valid = v;
    #1;
    chk("R6 rd_data", 192'(rd_data), 192'(model_read(model, o, f)));
    if (v) model = model_next(model, o, f, s, t);
    @(negedge clk);
    chk(v ? {tag_of(o), " R2 acc"} : "R10 acc held", acc_out, model);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset", acc_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", acc_out, '0);

    step(8, 0, 64'h0102_0304_0506_0708, '0, 1'b1);
    step(9, 0, 64'h11_22_33_44_55_66_77_88, 64'h80_7f_01_ff_00_90_10_c0, 1'b1);
    step(8, 1, 64'hdead_beef_1234_8001, '0, 1'b1);
    step(10, 1, '0, '0, 1'b1);
    step(11, 0, '0, '0, 1'b1);
    step(12, 1, '0, '0, 1'b1);
    step(1, 1, 64'h8000_7fff_ffff_0002, 64'h8000_8000_ffff_fffd, 1'b1);
    step(3, 0, 64'h80_80_7f_7f_ff_01_00_05, 64'h80_7f_80_7f_ff_ff_33_fb, 1'b1);
    step(13, 0, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 1'b1);
    step(15, 1, 64'h1234, 64'h5678, 1'b1);
    step(5, 0, 64'h7f7f_7f7f_7f7f_7f7f, 64'h7f7f_7f7f_7f7f_7f7f, 1'b0);

    step(7, 0, 64'h5555, 64'h5555, 1'b1);
    chk("R5 cleared by equal subtract", acc_out, '0);
    for (int k = 0; k < 1024; k++) begin
      op = 4'd0; fmt = 1'b0; vs = {8{8'h80}}; vt = {8{8'h80}}; valid = 1'b1;
      model = model_next(model, 0, 0, vs, vt);
      @(negedge clk);
      if (k == 511) chk("R5 half wrap", acc_out, {8{24'h800000}});
    end
    chk("R5 full wrap", acc_out, '0);

    for (int n = 0; n < 3000; n++) begin
      int o = int'($urandom_range(0, 15));
      int f = int'($urandom_range(0, 1));
      logic v = ($urandom_range(0, 7) != 0);
      step(o, f, {$urandom, $urandom}, {$urandom, $urandom}, v);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule